// File: doc/BRIEF.md
# Self-Clocking Type/Data Frame Serializer

This block sends one 28-bit serial frame each time it is asked to. A frame holds an 8-bit type code and a 16-bit data word. Fixed marker bits and a parity bit surround these two fields. The line uses biphase-mark coding, so the receiver recovers the clock from the line itself. Every bit cell opens with a change of line level. A one has a second change halfway through the cell, and a zero has none.

The user presents a type code and a data word together with a one-cycle send strobe. The block captures both values on the cycle it accepts the strobe. It raises a busy flag and shifts the frame out at the configured bit rate, which is 10 Mbit/s by default. A divider derives the timing from the system clock and produces two half-cell ticks per bit. Frame spacing, which is normally 10 µs, is left to whatever drives the strobe. Between frames the line rests at its last level.

Top module: `mdat_tx`

## Requirements
- R1: While reset is asserted and on leaving it, `lineOut` equals `IDLE_LEVEL` (default 0) and `busy` is 0.
- R2: When `sendStrobe` is high at a clock edge with `busy` low, `busy` is 1 after that edge and `lineOut` changes level at that same edge, which opens the first cell.
- R3: The frame's 28 bits go out in this order: a 1, a 0, the type code MSB first, the data word MSB first, a parity bit, and a final 1.
- R4: With `ODD_PARITY`=1 (the default), the parity bit makes the count of ones across the first 26 bits plus the parity bit odd. With `ODD_PARITY`=0 that count is even.
- R5: Every bit cell begins with a change of `lineOut` level.
- R6: A one bit has a further level change exactly halfway through its cell. A zero bit holds its level for the whole cell.
- R7: Each cell lasts 2·H clocks, where H = `CLK_FREQ_HZ`/(2·`BIT_RATE_HZ`), which is 5 by default. Inside a frame, `lineOut` changes only on clock edges that are a whole multiple of H after the accepting edge.
- R8: `busy` stays high for exactly 28·2·H clocks and then drops. No level change occurs at the edge where it drops.
- R9: While `busy` is low, `lineOut` holds the level it had at the end of the last frame.
- R10: A `sendStrobe` that arrives while `busy` is high is ignored. The frame in progress is unchanged, even if `typeCode` and `dataWord` change, and no further frame follows it.
- R11: A `sendStrobe` held high through the end of a frame is accepted on the first edge after `busy` drops, which starts the next frame with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sendStrobe | input | 1 | Request to send a frame; honoured only while idle |
| typeCode | input | TYPE_W (8) | Type field, captured at acceptance |
| dataWord | input | DATA_W (16) | Data field, captured at acceptance |
| lineOut | output | 1 | Biphase-mark coded serial line |
| busy | output | 1 | High while a frame is on the line |

## Verification
The hardest case to reach from the ports is the hand-over between frames. The strobe has to be high on exactly the first edge after `busy` falls, and the new frame has to start from whatever level the previous frame left on the line. The stimulus gets there by holding the strobe high across the whole of one frame with new field values already applied. The same strobe then also tests that a request made during a frame is ignored. A separate one-cycle strobe in mid-frame, together with changed field inputs, shows that captured values are immune to later input changes. The monitor decodes the line by sampling each half cell and the cycle just before it. As a result, a misplaced transition, a lost start edge or a wrong cell length appears as a decoding mismatch against the frame queued by the driver.

// File: rtl/mdat_tx_pkg.sv
package mdat_tx_pkg;

  // Strobes issued by the sequencer to the shifting datapath.
  typedef struct packed {
    logic load;      // capture a new frame, open the first cell
    logic midCell;   // halfway point of the current cell
    logic nextCell;  // close this cell and open the following one
    logic finish;    // last cell closed, frame complete
  } txStrobes_t;

endpackage

// File: rtl/mdat_tx_ctrl.sv
module mdat_tx_ctrl
  import mdat_tx_pkg::*;
#(
  parameter int HALF_DIV   = 5,
  parameter int FRAME_BITS = 28
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sendStrobe,
  output logic       busy,
  output txStrobes_t strobes
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  typedef enum logic {ST_IDLE, ST_SEND} txState_t;

  txState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             secondHalf;
  logic             halfTick;
  logic             lastCell;

  assign halfTick = (state == ST_SEND) && (divCnt == DIV_LAST);
  assign lastCell = (bitCnt == BIT_LAST);

  always_comb begin
    strobes          = '0;
    strobes.load     = (state == ST_IDLE) && sendStrobe;
    strobes.midCell  = halfTick && !secondHalf;
    strobes.nextCell = halfTick && secondHalf && !lastCell;
    strobes.finish   = halfTick && secondHalf && lastCell;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      divCnt     <= '0;
      bitCnt     <= '0;
      secondHalf <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sendStrobe) begin
            state      <= ST_SEND;
            divCnt     <= '0;
            bitCnt     <= '0;
            secondHalf <= 1'b0;
          end
        end
        ST_SEND: begin
          if (halfTick) begin
            divCnt     <= '0;
            secondHalf <= !secondHalf;
            if (secondHalf) begin
              if (lastCell) state <= ST_IDLE;
              else          bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_SEND);

endmodule

// File: rtl/mdat_tx_datapath.sv
module mdat_tx_datapath
  import mdat_tx_pkg::*;
#(
  parameter int   TYPE_W     = 8,
  parameter int   DATA_W     = 16,
  parameter bit   ODD_PARITY = 1'b1,
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [TYPE_W-1:0] typeCode,
  input  logic [DATA_W-1:0] dataWord,
  output logic              lineOut
);

  localparam int BODY_W     = 2 + TYPE_W + DATA_W;
  localparam int FRAME_BITS = BODY_W + 2;

  logic [BODY_W-1:0]     frameBody;
  logic                  parityBit;
  logic [FRAME_BITS-1:0] shiftReg;
  logic                  lineReg;

  assign frameBody = {2'b10, typeCode, dataWord};

  generate
    if (ODD_PARITY) begin : g_odd
      assign parityBit = ~(^frameBody);
    end else begin : g_even
      assign parityBit = ^frameBody;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      lineReg  <= IDLE_LEVEL;
    end else begin
      if (strobes.load) begin
        shiftReg <= {frameBody, parityBit, 1'b1};
        lineReg  <= ~lineReg;
      end else if (strobes.midCell) begin
        if (shiftReg[FRAME_BITS-1]) lineReg <= ~lineReg;
      end else if (strobes.nextCell) begin
        shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
        lineReg  <= ~lineReg;
      end else if (strobes.finish) begin
        shiftReg <= '0;
      end
    end
  end

  assign lineOut = lineReg;

endmodule

// File: rtl/mdat_tx.sv
module mdat_tx
  import mdat_tx_pkg::*;
#(
  parameter int   CLK_FREQ_HZ = 100_000_000,
  parameter int   BIT_RATE_HZ = 10_000_000,
  parameter int   TYPE_W      = 8,
  parameter int   DATA_W      = 16,
  parameter bit   ODD_PARITY  = 1'b1,
  parameter logic IDLE_LEVEL  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sendStrobe,
  input  logic [TYPE_W-1:0] typeCode,
  input  logic [DATA_W-1:0] dataWord,
  output logic              lineOut,
  output logic              busy
);

  localparam int RAW_DIV    = CLK_FREQ_HZ / (2 * BIT_RATE_HZ);
  localparam int HALF_DIV   = (RAW_DIV < 1) ? 1 : RAW_DIV;
  localparam int FRAME_BITS = TYPE_W + DATA_W + 4;

  txStrobes_t strobes;

  mdat_tx_ctrl #(
    .HALF_DIV  (HALF_DIV),
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sendStrobe(sendStrobe),
    .busy      (busy),
    .strobes   (strobes)
  );

  mdat_tx_datapath #(
    .TYPE_W    (TYPE_W),
    .DATA_W    (DATA_W),
    .ODD_PARITY(ODD_PARITY),
    .IDLE_LEVEL(IDLE_LEVEL)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .typeCode(typeCode),
    .dataWord(dataWord),
    .lineOut (lineOut)
  );

endmodule

// File: rtl/mdat_tx_checker.sv
module mdat_tx_checker #(
  parameter int HALF_DIV   = 5,
  parameter int FRAME_BITS = 28
) (
  input logic clk,
  input logic rstN,
  input logic sendStrobe,
  input logic lineOut,
  input logic busy
);

  localparam int FRAME_CLKS = FRAME_BITS * 2 * HALF_DIV;
  localparam int CYC_W      = $clog2(FRAME_CLKS + 2);

  logic [CYC_W-1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rstN) cyc <= '0;
    else       cyc <= busy ? cyc + 1'b1 : '0;
  end

  p_accept_on_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(sendStrobe));

  p_first_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (lineOut != $past(lineOut)));

  p_half_grid_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (lineOut != $past(lineOut)))
      |-> ((int'(cyc) % HALF_DIV) == 0));

  p_frame_length_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (int'(cyc) == FRAME_CLKS));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(lineOut));

endmodule

bind mdat_tx mdat_tx_checker #(
  .HALF_DIV  (HALF_DIV),
  .FRAME_BITS(FRAME_BITS)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .sendStrobe(sendStrobe),
  .lineOut   (lineOut),
  .busy      (busy)
);

// File: tb/mdat_tx_bench.sv
`timescale 1ns/1ps
module mdat_tx_bench;

  localparam int H      = 100_000_000 / (2 * 10_000_000);
  localparam int NBITS  = 28;
  localparam int WDOG   = 200_000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sendStrobe = 1'b0;
  logic [7:0]  typeCode = '0;
  logic [15:0] dataWord = '0;
  logic        lineOut;
  logic        busy;

  int checks = 0;
  int errors = 0;
  logic [NBITS-1:0] expQ[$];

  always #10 clk = ~clk;

  mdat_tx u_mdat_tx (
    .clk(clk), .rstN(rstN), .sendStrobe(sendStrobe),
    .typeCode(typeCode), .dataWord(dataWord),
    .lineOut(lineOut), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NBITS-1:0] makeFrame(input logic [7:0] t, input logic [15:0] d);
    logic [25:0] body;
    int ones;
    body = {1'b1, 1'b0, t, d};
    ones = 0;
    for (int i = 0; i < 26; i++) ones += body[i];
    return {body, (ones % 2 == 0) ? 1'b1 : 1'b0, 1'b1};
  endfunction

  task automatic waitIdle();
    do @(negedge clk); while (busy);
  endtask

  task automatic send(input logic [7:0] t, input logic [15:0] d);
    waitIdle();
    typeCode   = t;
    dataWord   = d;
    sendStrobe = 1'b1;
    expQ.push_back(makeFrame(t, d));
    @(negedge clk);
    sendStrobe = 1'b0;
  endtask

  // Monitor: decode the line cell by cell and score against the queue.
  initial begin
    logic prevBusy, prevLine;
    prevBusy = 1'b0;
    prevLine = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && busy && !prevBusy) begin
        logic [NBITS-1:0] got, exp;
        logic lvl, a, b, late;
        bit startOk, gridOk, busyBefore;
        startOk = 1; gridOk = 1; busyBefore = 0;
        lvl = prevLine;
        for (int i = 0; i < NBITS; i++) begin
          a = lineOut;
          if (a == lvl) startOk = 0;
          repeat (H - 1) @(negedge clk);
          late = lineOut;
          if (late != a) gridOk = 0;
          @(negedge clk);
          b = lineOut;
          got[NBITS-1-i] = (a != b);
          repeat (H - 1) @(negedge clk);
          late = lineOut;
          if (late != b) gridOk = 0;
          if (i == NBITS - 1) busyBefore = busy;
          @(negedge clk);
          lvl = b;
        end
        check(startOk, "R5 start-of-cell transition", {31'b0, startOk}, 32'd1);
        check(gridOk, "R7 changes only on half-cell grid", {31'b0, gridOk}, 32'd1);
        check(busyBefore && !busy, "R8 busy length 280 clocks", {30'b0, busyBefore, busy}, 32'b10);
        check(lineOut == lvl, "R8 no change at end of frame", {31'b0, lineOut}, {31'b0, lvl});
        if (expQ.size() == 0) begin
          check(0, "R10 unexpected extra frame", got, 32'd0);
        end else begin
          exp = expQ.pop_front();
          check(got[NBITS-1:2] == exp[NBITS-1:2] && got[0] == exp[0],
                "R3 R6 field order and bit coding", got, exp);
          check(got[1] == exp[1], "R4 odd parity bit", {31'b0, got[1]}, {31'b0, exp[1]});
        end
      end
      prevBusy = busy;
      prevLine = lineOut;
    end
  end

  // Watchdog
  initial begin
    repeat (WDOG) @(posedge clk);
    check(0, "watchdog expired", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic holdLvl;
    bit stayedIdle;
    repeat (5) @(negedge clk);
    check(lineOut == 1'b0, "R1 reset line level", {31'b0, lineOut}, 32'd0);
    check(busy == 1'b0, "R1 reset busy", {31'b0, busy}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(lineOut == 1'b0 && !busy, "R1 after reset release", {30'b0, busy, lineOut}, 32'd0);

    // R2: accept and first edge
    typeCode = 8'hA5; dataWord = 16'h1234; sendStrobe = 1'b1;
    expQ.push_back(makeFrame(8'hA5, 16'h1234));
    @(negedge clk);
    sendStrobe = 1'b0;
    check(busy && lineOut == 1'b1, "R2 busy and first edge after accept", {30'b0, busy, lineOut}, 32'b11);

    send(8'h00, 16'h0000);
    send(8'hFF, 16'hFFFF);
    send(8'h5A, 16'hC3C3);

    // R9: idle line holds
    waitIdle();
    holdLvl = lineOut;
    repeat (100) @(negedge clk);
    check(lineOut == holdLvl && !busy, "R9 idle line holds level", {31'b0, lineOut}, {31'b0, holdLvl});

    // R10: mid-frame strobe with changed inputs is ignored
    send(8'h3C, 16'h0F0F);
    repeat (60) @(negedge clk);
    typeCode = 8'h11; dataWord = 16'h2222; sendStrobe = 1'b1;
    @(negedge clk);
    sendStrobe = 1'b0;
    waitIdle();
    stayedIdle = 1;
    repeat (300) begin
      @(negedge clk);
      if (busy) stayedIdle = 0;
    end
    check(stayedIdle, "R10 strobe during frame ignored", {31'b0, stayedIdle}, 32'd1);

    // R11: strobe held across end of frame starts next frame at once
    typeCode = 8'h81; dataWord = 16'h8001; sendStrobe = 1'b1;
    expQ.push_back(makeFrame(8'h81, 16'h8001));
    @(negedge clk);
    typeCode = 8'h7E; dataWord = 16'h7FFE;
    expQ.push_back(makeFrame(8'h7E, 16'h7FFE));
    do @(negedge clk); while (busy);
    @(negedge clk);
    check(busy, "R11 back-to-back accept", {31'b0, busy}, 32'd1);
    sendStrobe = 1'b0;

    send(8'h01, 16'h8000);
    waitIdle();
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R3 all queued frames seen", expQ.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule